// File: doc/BRIEF.md
# Display Controller Register Bank with Atomic Set/Clear Aliases

This block is the software-visible register bank of a raster display controller. A host reaches it over a simple 32-bit bus with a write strobe, a read strobe, a byte address and a data word. Each register occupies a 16-byte slot. Within a slot there are three ways to write. A plain write replaces the writable bits. A set alias ORs the write data into the register. A clear alias removes the bits that are 1 in the write data. Because of the two aliases, a driver can change one control bit without a read-modify-write sequence.

The control word holds several fields: run, dot-clock mode, master, bus width, word length, clock gate and soft reset. A second configuration register holds a FIFO-clear bit and a 4-bit byte-valid mask. The frame-buffer base is double-buffered. Software writes the next-buffer register at any time. The display engine's frame-start strobe copies that value into the scan-base register, which is the address actually being scanned.

The run bit is the output of a three-state machine. RS_IDLE means not running. RS_ACTIVE means running. RS_DRAIN means dot-clock mode was cleared while running, and the engine is emptying its FIFO. The transitions are:
- RS_IDLE to RS_ACTIVE (start): a control write leaves run at 1.
- RS_ACTIVE to RS_IDLE (stop): a control write leaves run at 0.
- RS_ACTIVE to RS_DRAIN (drain): a control write takes dot-clock mode from 1 to 0 while run stays 1.
- RS_DRAIN to RS_IDLE (drained): `drain_done` is high, or a control write leaves run at 0.
- Any state to RS_IDLE (soft reset): the soft-reset bit becomes 1.

Top module: `lcd_ctrl_regs`

## Requirements
- R1: After reset, every register reads 0, the run bit is 0 and `scan_base_o` is 0.
- R2: There are four registers at byte offsets 0x00 (control), 0x10 (configuration), 0x20 (next buffer) and 0x30 (scan base). Within a slot, offset +0x0 replaces the writable bits with the write data, +0x4 ORs the write data into them, and +0x8 clears every writable bit that is 1 in the write data.
- R3: A read at +0x0, +0x4 or +0x8 of a slot returns the same value. `bus_rdata` is 0 whenever `bus_re` is low.
- R4: In the control word, bit 31 is soft reset, bit 30 is clock gate, bit 17 is dot-clock mode, bits 11:10 are bus width, bits 9:8 are word length, bit 5 is master and bit 0 is run. In the configuration register, bit 21 is FIFO clear and bits 19:16 are the byte-valid mask. All other bits of these two registers read 0 and ignore writes. The next-buffer register is 32 bits wide and fully writable.
- R5: An access at slot offset +0xC, at an address of 0x40 or above, or at an address that is not a multiple of 4 reads 0 and changes nothing. Writes to the scan-base register (0x30 to 0x38) are ignored.
- R6: A write to the next-buffer register leaves `scan_base_o` unchanged. A `frame_start` pulse copies the next-buffer value into the scan base. When a write and `frame_start` fall in the same cycle, the scan base takes the value held before the write.
- R7: A control write that leaves run at 1 starts the block from idle. A control write that leaves run at 0 stops it at once, including while draining.
- R8: Clearing dot-clock mode while running keeps run at 1 until `drain_done` is seen, and run reads 0 from the following cycle. `drain_done` has no effect while the block is not draining.
- R9: While soft reset is 1, every other control bit, the configuration register, the next buffer and the scan base are held at 0, and the run bit is held at 0. Writes to these registers have no effect until soft reset is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| frame_start | input | 1 | Vertical-sync strobe from the display engine |
| drain_done | input | 1 | FIFO-empty indication from the display engine |
| ctrl_o | output | 32 | Control word, including the run bit |
| cfg_o | output | 32 | Configuration register |
| scan_base_o | output | 32 | Frame-buffer base being scanned |

## Verification
Two functions can land in the same cycle, and both are provoked by driving their stimuli on the same falling edge. In the first, a next-buffer write coincides with `frame_start`; the check expects the scan base to take the old buffer value and the next-buffer read to return the new one. In the second, a control write that clears run arrives while the block is draining; the check expects run to drop on that write alone, without waiting for `drain_done`. Around both cases, alias writes to every register are swept over all three operations and several data patterns, and a bench model predicts each read.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_BITS = $clog2(NUM_SLOTS);

    localparam int SLOT_CTRL = 0;
    localparam int SLOT_CFG  = 1;
    localparam int SLOT_NEXT = 2;
    localparam int SLOT_SCAN = 3;

    localparam int B_SRST = 31;
    localparam int B_GATE = 30;
    localparam int B_DOT  = 17;
    localparam int B_MSTR = 5;
    localparam int B_RUN  = 0;

    localparam logic [REG_W-1:0] CTRL_WMASK = (REG_W'(1) << B_SRST) | (REG_W'(1) << B_GATE)
                                            | (REG_W'(1) << B_DOT)  | 32'h0000_0F00
                                            | (REG_W'(1) << B_MSTR) | (REG_W'(1) << B_RUN);
    localparam logic [REG_W-1:0] CFG_WMASK  = 32'h002F_0000;
    localparam logic [REG_W-1:0] SRST_ONLY  = REG_W'(1) << B_SRST;
    localparam logic [REG_W-1:0] RUN_ONLY   = REG_W'(1) << B_RUN;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_ACTIVE = 2'd1,
        RS_DRAIN  = 2'd2
    } run_state_e;

    function automatic logic [REG_W-1:0] apply_op(input acc_op_e op,
                                                  input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] wd,
                                                  input logic [REG_W-1:0] mask);
        logic [REG_W-1:0] res;
        unique case (op)
            OP_WRITE: res = (old_v & ~mask) | (wd & mask);
            OP_SET:   res = old_v | (wd & mask);
            OP_CLEAR: res = old_v & ~(wd & mask);
            default:  res = old_v;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/lcdr_decode.sv
module lcdr_decode
    import lcdr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_SLOTS-1:0] sel,
    output acc_op_e              op
);
    localparam int SLOT_LO = 4;
    localparam int SLOT_HI = SLOT_LO + SLOT_BITS - 1;

    logic                 in_range;
    logic [SLOT_BITS-1:0] slot;

    assign op       = acc_op_e'(addr[3:2]);
    assign slot     = addr[SLOT_HI:SLOT_LO];
    assign in_range = (addr[ADDR_W-1:SLOT_HI+1] == '0) && (addr[1:0] == 2'b00)
                      && (op != OP_NONE);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
        assign sel[i] = in_range && (slot == SLOT_BITS'(i));
    end
endmodule

// File: rtl/lcdr_run_fsm.sv
module lcdr_run_fsm
    import lcdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic ctrl_wr,
    input  logic run_req,
    input  logic dot_now,
    input  logic dot_next,
    input  logic drain_done,
    output logic run
);
    run_state_e st_q, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        if (srst) begin
            st_nx = RS_IDLE;
        end else begin
            unique case (st_q)
                RS_IDLE: begin
                    if (ctrl_wr && run_req) st_nx = RS_ACTIVE;
                end
                RS_ACTIVE: begin
                    if (ctrl_wr && !run_req)      st_nx = RS_IDLE;
                    else if (dot_now && !dot_next) st_nx = RS_DRAIN;
                end
                RS_DRAIN: begin
                    if (ctrl_wr && !run_req) st_nx = RS_IDLE;
                    else if (drain_done)     st_nx = RS_IDLE;
                end
                default: st_nx = RS_IDLE;
            endcase
        end
    end

    always_comb begin
        run = (st_q != RS_IDLE);
    end
endmodule

// File: rtl/lcdr_fb_shadow.sv
module lcdr_fb_shadow
    import lcdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             wr_en,
    input  acc_op_e          wr_op,
    input  logic [REG_W-1:0] wdata,
    input  logic             frame_start,
    output logic [REG_W-1:0] next_q,
    output logic [REG_W-1:0] scan_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q <= '0;
            scan_q <= '0;
        end else if (hold) begin
            next_q <= '0;
            scan_q <= '0;
        end else begin
            if (wr_en)       next_q <= apply_op(wr_op, next_q, wdata, '1);
            if (frame_start) scan_q <= next_q;
        end
    end
endmodule

// File: rtl/lcd_ctrl_regs.sv
module lcd_ctrl_regs
    import lcdr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              frame_start,
    input  logic              drain_done,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       cfg_o,
    output logic [31:0]       scan_base_o
);
    logic [NUM_SLOTS-1:0] sel;
    acc_op_e              op;
    logic [REG_W-1:0]     ctrl_q, ctrl_view, ctrl_applied, ctrl_next;
    logic [REG_W-1:0]     cfg_q, next_q, scan_q, rd_mux;
    logic                 run, wr_ctrl, wr_cfg, wr_next, srst_next;

    lcdr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .op   (op)
    );

    assign wr_ctrl = bus_we & sel[SLOT_CTRL];
    assign wr_cfg  = bus_we & sel[SLOT_CFG];
    assign wr_next = bus_we & sel[SLOT_NEXT];

    assign ctrl_view    = ctrl_q | (run ? RUN_ONLY : '0);
    assign ctrl_applied = apply_op(op, ctrl_view, bus_wdata, CTRL_WMASK);
    assign ctrl_next    = wr_ctrl ? ctrl_applied : ctrl_view;
    assign srst_next    = ctrl_next[B_SRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (srst_next) ctrl_q <= SRST_ONLY;
        else                ctrl_q <= ctrl_next & ~RUN_ONLY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_q <= '0;
        else if (srst_next) cfg_q <= '0;
        else if (wr_cfg)    cfg_q <= apply_op(op, cfg_q, bus_wdata, CFG_WMASK);
    end

    lcdr_run_fsm u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst_next),
        .ctrl_wr    (wr_ctrl),
        .run_req    (ctrl_applied[B_RUN]),
        .dot_now    (ctrl_view[B_DOT]),
        .dot_next   (ctrl_next[B_DOT]),
        .drain_done (drain_done),
        .run        (run)
    );

    lcdr_fb_shadow u_fb (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (srst_next),
        .wr_en       (wr_next),
        .wr_op       (op),
        .wdata       (bus_wdata),
        .frame_start (frame_start),
        .next_q      (next_q),
        .scan_q      (scan_q)
    );

    always_comb begin
        rd_mux = '0;
        if (sel[SLOT_CTRL]) rd_mux = ctrl_view;
        if (sel[SLOT_CFG])  rd_mux = cfg_q;
        if (sel[SLOT_NEXT]) rd_mux = next_q;
        if (sel[SLOT_SCAN]) rd_mux = scan_q;
    end

    assign bus_rdata   = bus_re ? rd_mux : '0;
    assign ctrl_o      = ctrl_view;
    assign cfg_o       = cfg_q;
    assign scan_base_o = scan_q;
endmodule

// File: rtl/lcd_ctrl_regs_chk.sv
module lcd_ctrl_regs_chk
    import lcdr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic        frame_start,
    input logic        drain_done,
    input logic [31:0] ctrl_o,
    input logic [31:0] cfg_o,
    input logic [31:0] scan_base_o,
    input logic [31:0] next_q
);
    // R4: bits outside the defined fields never become 1
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_o & ~CTRL_WMASK) == '0) && ((cfg_o & ~CFG_WMASK) == '0));

    // R6: without a frame strobe the scan base does not move
    a_r6_scan_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !bus_we) |=> $stable(scan_base_o));

    // R6: a frame strobe copies the buffered address
    a_r6_frame_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !bus_we) |=> (scan_base_o == $past(next_q)));

    // R7: run never sets itself without a bus write
    a_r7_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[B_RUN] && !bus_we) |=> !ctrl_o[B_RUN]);

    // R8: with dot-clock mode off, run holds until drain completes
    a_r8_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[B_RUN] && !ctrl_o[B_DOT] && !drain_done && !bus_we) |=> ctrl_o[B_RUN]);

    // R9: soft reset pins everything else at zero
    a_r9_srst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[B_SRST] |-> ((ctrl_o[30:0] == '0) && (cfg_o == '0)
                            && (scan_base_o == '0) && (next_q == '0)));
endmodule

bind lcd_ctrl_regs lcd_ctrl_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .frame_start (frame_start),
    .drain_done  (drain_done),
    .ctrl_o      (ctrl_o),
    .cfg_o       (cfg_o),
    .scan_base_o (scan_base_o),
    .next_q      (next_q)
);

// File: tb/lcd_ctrl_regs_tb.sv
`timescale 1ns/1ps
module lcd_ctrl_regs_tb;
    localparam logic [31:0] M_CTRL  = 32'hC002_0F21;
    localparam logic [31:0] M_CFG   = 32'h002F_0000;
    localparam logic [31:0] SWEEP_C = 32'h4000_0F20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_start = 1'b0, drain_done = 1'b0;
    logic [31:0] ctrl_o, cfg_o, scan_base_o;

    int total = 0, bad = 0;
    logic [31:0] m_ctrl, m_cfg, m_next, m_scan;

    always #4 clk = ~clk;

    lcd_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_start(frame_start), .drain_done(drain_done),
        .ctrl_o(ctrl_o), .cfg_o(cfg_o), .scan_base_o(scan_base_o)
    );

    function automatic logic [31:0] bm(input int op, input logic [31:0] o,
                                       input logic [31:0] d, input logic [31:0] m);
        if (op == 0) return (o & ~m) | (d & m);
        if (op == 1) return o | (d & m);
        return o & ~(d & m);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_re = 1'b1; bus_addr = a; #1;
        check(tag, bus_rdata, exp);
        bus_re = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic rd_all(input string tag);
        rd(8'h00, m_ctrl, tag); rd(8'h10, m_cfg, tag);
        rd(8'h20, m_next, tag); rd(8'h30, m_scan, tag);
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_ctrl = 0; m_cfg = 0; m_next = 0; m_scan = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_all("R1 reset");
        check("R1 scan_base", scan_base_o, 32'h0);

        // R2 R3 R4 sweep: every op, several patterns, reads at all aliases
        for (int s = 0; s < 3; s++) begin
            for (int op = 0; op < 3; op++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [31:0] pat, d, msk;
                    logic [7:0]  base;
                    pat  = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5A5_A5A5 :
                           (p == 2) ? 32'h5A5A_5A5A : 32'h0F0F_00F0;
                    base = 8'(s * 16);
                    d    = (s == 0) ? (pat & SWEEP_C) : pat;
                    msk  = (s == 0) ? M_CTRL : (s == 1) ? M_CFG : 32'hFFFF_FFFF;
                    wr(base + 8'(op * 4), d);
                    if (s == 0)      m_ctrl = bm(op, m_ctrl, d, msk);
                    else if (s == 1) m_cfg  = bm(op, m_cfg, d, msk);
                    else             m_next = bm(op, m_next, d, msk);
                    for (int a = 0; a < 3; a++) begin
                        rd(base + 8'(a * 4),
                           (s == 0) ? m_ctrl : (s == 1) ? m_cfg : m_next, "R2 R3 R4 alias");
                    end
                end
            end
        end
        check("R6 scan unchanged by next writes", scan_base_o, 32'h0);

        // R3 read strobe low gives zero
        bus_addr = 8'h10; bus_re = 1'b0; #1;
        check("R3 re low", bus_rdata, 32'h0);

        // R5 unmapped and read-only
        wr(8'h0C, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF); wr(8'hF4, 32'hFFFF_FFFF);
        wr(8'h21, 32'hFFFF_FFFF); wr(8'h30, 32'h1234_5678);
        wr(8'h34, 32'hFFFF_FFFF);
        rd_all("R5 unmapped writes ignored");
        rd(8'h0C, 32'h0, "R5 unmapped read");
        rd(8'h40, 32'h0, "R5 out of range read");
        rd(8'h22, 32'h0, "R5 misaligned read");
        check("R5 ctrl port", ctrl_o, m_ctrl);

        // R6 shadowing
        wr(8'h20, 32'h0000_1000); m_next = 32'h0000_1000;
        check("R6 write does not scan", scan_base_o, m_scan);
        frame(); m_scan = m_next;
        check("R6 frame copies", scan_base_o, 32'h0000_1000);
        @(negedge clk); bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h0000_2000;
        frame_start = 1'b1;
        @(negedge clk); bus_we = 1'b0; frame_start = 1'b0;
        check("R6 collision scan old", scan_base_o, 32'h0000_1000);
        rd(8'h20, 32'h0000_2000, "R6 collision next new");
        frame(); m_scan = 32'h0000_2000;
        check("R6 second frame", scan_base_o, 32'h0000_2000);
        rd(8'h30, 32'h0000_2000, "R6 scan read");
        m_next = 32'h0000_2000;

        // R7 R8 run control
        wr(8'h00, 32'h0002_0001);
        check("R7 start", ctrl_o, 32'h0002_0001);
        wr(8'h08, 32'h0002_0000);
        check("R8 drain keeps run", ctrl_o, 32'h0000_0001);
        repeat (5) @(negedge clk);
        check("R8 still draining", ctrl_o[0], 1'b1);
        @(negedge clk); drain_done = 1'b1;
        @(negedge clk); drain_done = 1'b0;
        check("R8 drained", ctrl_o, 32'h0);
        wr(8'h04, 32'h0002_0001);
        check("R7 start via set alias", ctrl_o, 32'h0002_0001);
        @(negedge clk); drain_done = 1'b1;
        @(negedge clk); drain_done = 1'b0;
        check("R8 drain_done ignored while active", ctrl_o, 32'h0002_0001);
        wr(8'h08, 32'h0000_0001);
        check("R7 stop via clear alias", ctrl_o, 32'h0002_0000);
        wr(8'h04, 32'h0000_0001);
        wr(8'h00, 32'h0000_0001);
        check("R8 plain write enters drain", ctrl_o, 32'h0000_0001);
        wr(8'h08, 32'h0000_0001);
        check("R7 stop while draining", ctrl_o, 32'h0);

        // R9 soft reset
        wr(8'h14, 32'h000F_0000); wr(8'h20, 32'hABCD_0000); frame();
        wr(8'h04, 32'h0002_0321);
        wr(8'h04, 32'h8000_0000);
        m_ctrl = 32'h8000_0000; m_cfg = 0; m_next = 0; m_scan = 0;
        rd_all("R9 soft reset clears");
        check("R9 scan port", scan_base_o, 32'h0);
        wr(8'h14, 32'h000F_0000); wr(8'h24, 32'h0000_00FF); wr(8'h04, 32'h0000_0001);
        rd_all("R9 writes held");
        wr(8'h08, 32'h8000_0000); m_ctrl = 0;
        rd(8'h00, 32'h0, "R9 released");
        wr(8'h14, 32'h000F_0000);
        rd(8'h10, 32'h000F_0000, "R9 writes work after release");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule